// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Code Register Interface

This block is a synchronous model of the digital front end of a two-channel 12-bit converter that is fed from an 8-bit processor bus. A 12-bit code for each channel is built from two bus writes: one carries the lower 8 bits and the other carries the upper 4 bits. The two writes may come in either order. Each channel has two stages. An input stage holds a low byte and a high nibble. An output stage holds the 12-bit code that the converter would use. All control inputs are sampled on one system clock.

The output stage is filled in one of two ways. In automatic mode the load strobe is held low, so the output of the addressed channel follows every write, and the second byte of a pair completes the word. Four writes update both channels. In strobed mode the load strobe stays high while the four bytes are written. A single low-then-high pulse on the strobe then copies both channels' input stages to their output stages on the same clock edge. An active-low clear input forces every register to zero.

Top module: `dacbuf_top`

## Requirements
- R1: In any clock cycle in which clrN is sampled low, every input and output register of both channels becomes zero. codeA and codeB read 0 after that edge.
- R2: When wrN is sampled low with hiSel = 0, busData[7:0] is stored in the low-byte input register of the addressed channel. This is bits 7..0 of the code.
- R3: When wrN is sampled low with hiSel = 1, busData[3:0] is stored in the high-nibble input register of the addressed channel. This is bits 11..8 of the code. busData[7:4] is ignored.
- R4: chSel = 0 addresses channel A and chSel = 1 addresses channel B. A write never changes the registers of the other channel.
- R5: While wrN is sampled high, the input registers hold their contents, whatever busData, hiSel or chSel do.
- R6: A load edge is a cycle in which loadN is sampled high after it was sampled low in the previous cycle. On a load edge, both output registers take the contents of their channel's input registers, including any write made in that same cycle. The new codes are visible after that clock edge.
- R7: When wrN and loadN are both sampled low, the output register of the addressed channel takes the updated input word on the same edge as the input register. Writing the two bytes in either order gives the same 12-bit code.
- R8: While loadN is sampled high in the current cycle and in the previous cycle, codeA and codeB do not change, whatever writes occur.
- R9: If clrN is released while wrN is high, the zeros remain in all registers. A later load edge therefore gives codes of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| clrN | input | 1 | Active-low clear of all registers |
| wrN | input | 1 | Active-low write enable for the input registers |
| loadN | input | 1 | Active-low load strobe; the transfer happens on its rising edge |
| chSel | input | 1 | Channel select: 0 = channel A, 1 = channel B |
| hiSel | input | 1 | Byte select: 0 = low byte, 1 = high nibble |
| busData | input | 8 | Processor data bus |
| codeA | output | 12 | Output code of channel A |
| codeB | output | 12 | Output code of channel B |

## Verification
The assertions check four things on every cycle:
- the zero state after a clear;
- that the untouched channel keeps its value during a write;
- that the outputs stay frozen while the strobe stays high;
- that the byte and nibble placement is right in transparent mode.

The following behaviours live in the hidden input stage, so only the bench's scenarios can show them:
- a strobed transfer copies exactly the staged words;
- both byte orders produce the same word;
- bus activity with write high leaves the staged words untouched;
- the zeros stay latched after a clear that is released with write high.

The bench brings each of these out through a later load pulse.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] loLd;
    logic [NUM_CH-1:0] hiLd;
    logic [NUM_CH-1:0] passThru;
    logic              xfer;
    logic              clear;
  } strobe_t;
endpackage

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl
  import dacbuf_pkg::*;
(
  input  logic    clk,
  input  logic    clrN,
  input  logic    wrN,
  input  logic    loadN,
  input  logic    chSel,
  input  logic    hiSel,
  output strobe_t stb
);
  logic loadQ;
  logic wrAct;

  always_ff @(posedge clk) begin
    loadQ <= loadN;
  end

  assign wrAct = ~wrN & clrN;

  always_comb begin
    stb.clear = ~clrN;
    stb.xfer  = clrN & loadN & ~loadQ;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic hit;
    assign hit             = wrAct & (chSel == c[0]);
    assign stb.loLd[c]     = hit & ~hiSel;
    assign stb.hiLd[c]     = hit & hiSel;
    assign stb.passThru[c] = hit & ~loadN;
  end
endmodule

// File: rtl/dacbuf_dp.sv
module dacbuf_dp
  import dacbuf_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic                           clk,
  input  strobe_t                        stb,
  input  logic [BUS_W-1:0]               busData,
  output logic [NUM_CH-1:0][CODE_W-1:0]  codes
);
  localparam int HI_W = CODE_W - BUS_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [BUS_W-1:0]  loReg, loNext;
    logic [HI_W-1:0]   hiReg, hiNext;
    logic [CODE_W-1:0] outReg;

    always_comb begin
      loNext = stb.loLd[c] ? busData : loReg;
      hiNext = stb.hiLd[c] ? busData[HI_W-1:0] : hiReg;
    end

    always_ff @(posedge clk) begin
      if (stb.clear) begin
        loReg  <= '0;
        hiReg  <= '0;
        outReg <= '0;
      end else begin
        loReg <= loNext;
        hiReg <= hiNext;
        if (stb.xfer || stb.passThru[c]) begin
          outReg <= {hiNext, loNext};
        end
      end
    end

    assign codes[c] = outReg;
  end
endmodule

// File: rtl/dacbuf_top.sv
module dacbuf_top
  import dacbuf_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              wrN,
  input  logic              loadN,
  input  logic              chSel,
  input  logic              hiSel,
  input  logic [BUS_W-1:0]  busData,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB
);
  strobe_t                       stb;
  logic [NUM_CH-1:0][CODE_W-1:0] codes;

  dacbuf_ctrl u_ctrl (
    .clk   (clk),
    .clrN  (clrN),
    .wrN   (wrN),
    .loadN (loadN),
    .chSel (chSel),
    .hiSel (hiSel),
    .stb   (stb)
  );

  dacbuf_dp #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_dp (
    .clk     (clk),
    .stb     (stb),
    .busData (busData),
    .codes   (codes)
  );

  assign codeA = codes[0];
  assign codeB = codes[1];
endmodule

// File: rtl/dacbuf_chk.sv
module dacbuf_chk #(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              clrN,
  input logic              wrN,
  input logic              loadN,
  input logic              chSel,
  input logic              hiSel,
  input logic [BUS_W-1:0]  busData,
  input logic [CODE_W-1:0] codeA,
  input logic [CODE_W-1:0] codeB
);
  localparam int HI_W = CODE_W - BUS_W;
  logic loadQ;
  logic clrSeen = 1'b0;

  always_ff @(posedge clk) begin
    loadQ   <= loadN;
    clrSeen <= ~clrN;
  end

  always @(posedge clk) begin
    if (clrSeen) begin
      AST_CLEAR_ZERO: assert (codeA == '0 && codeB == '0); // R1
    end
  end

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!clrN)
    (loadN && loadQ) |=> ($stable(codeA) && $stable(codeB))); // R8

  AST_B_UNTOUCHED: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && !chSel && !(loadN && !loadQ)) |=> $stable(codeB)); // R4

  AST_A_UNTOUCHED: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && chSel && !(loadN && !loadQ)) |=> $stable(codeA)); // R4

  AST_PASS_LOW: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && !loadN && !chSel && !hiSel) |=> (codeA[BUS_W-1:0] == $past(busData))); // R7

  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (!clrN)
    (!wrN && !loadN && chSel && hiSel) |=> (codeB[CODE_W-1:BUS_W] == $past(busData[HI_W-1:0]))); // R3
endmodule

bind dacbuf_top dacbuf_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .clrN(clrN), .wrN(wrN), .loadN(loadN), .chSel(chSel),
  .hiSel(hiSel), .busData(busData), .codeA(codeA), .codeB(codeB)
);

// File: tb/tb_dacbuf_top.sv
module tb_dacbuf_top;
  logic        clk = 1'b0;
  logic        clrN = 1'b0, wrN = 1'b1, loadN = 1'b1, chSel = 1'b0, hiSel = 1'b0;
  logic [7:0]  busData = 8'h00;
  logic [11:0] codeA, codeB;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0]  mLo [2];
  logic [3:0]  mHi [2];
  logic [11:0] mOut [2];
  logic        mLoadQ = 1'b1;

  always #10 clk = ~clk;

  dacbuf_top dut (.clk(clk), .clrN(clrN), .wrN(wrN), .loadN(loadN), .chSel(chSel),
                  .hiSel(hiSel), .busData(busData), .codeA(codeA), .codeB(codeB));

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  function automatic string pickTag(input logic c, input logic w, input logic l);
    if (!c) return "R1";
    if (l && !mLoadQ) return "R6";
    if (!w && !l) return "R7";
    if (l) return "R8";
    return "R5";
  endfunction

  task automatic modelStep(input logic c, input logic w, input logic l,
                           input logic ch, input logic hs, input logic [7:0] d);
    if (!c) begin
      for (int i = 0; i < 2; i++) begin mLo[i] = 0; mHi[i] = 0; mOut[i] = 0; end
    end else begin
      if (!w) begin
        if (hs) mHi[ch] = d[3:0]; else mLo[ch] = d;
      end
      if (l && !mLoadQ) begin
        for (int i = 0; i < 2; i++) mOut[i] = {mHi[i], mLo[i]};
      end else if (!w && !l) begin
        mOut[ch] = {mHi[ch], mLo[ch]};
      end
    end
    mLoadQ = l;
  endtask

  task automatic step(input logic c, input logic w, input logic l, input logic ch,
                      input logic hs, input logic [7:0] d, input string tag);
    string t;
    @(negedge clk);
    clrN = c; wrN = w; loadN = l; chSel = ch; hiSel = hs; busData = d;
    t = (tag == "") ? pickTag(c, w, l) : tag;
    @(posedge clk);
    #1;
    modelStep(c, w, l, ch, hs, d);
    check({t, " chA"}, codeA, mOut[0]);
    check({t, " chB"}, codeB, mOut[1]);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: clear state
    step(0, 1, 1, 0, 0, 8'h00, "R1");
    step(0, 1, 1, 0, 0, 8'h00, "R1");
    // R7 R2 R3: automatic mode, low then high on A (bus[7:4] ignored, R3)
    step(1, 0, 0, 0, 0, 8'hA5, "R2");
    step(1, 0, 0, 0, 1, 8'hF7, "R3");
    // R7: reverse order on B gives the same word
    step(1, 0, 0, 1, 1, 8'h07, "R7");
    step(1, 0, 0, 1, 0, 8'hA5, "R7");
    check("R7 byte order", codeB, codeA);
    check("R7 word", codeA, 12'h7A5);
    // R8 R4: strobed loads, outputs frozen
    step(1, 1, 1, 0, 0, 8'h00, "R8");
    step(1, 0, 1, 0, 0, 8'h3C, "R8");
    step(1, 0, 1, 0, 1, 8'h02, "R8");
    step(1, 0, 1, 1, 0, 8'hC3, "R4");
    step(1, 0, 1, 1, 1, 8'h0E, "R8");
    // R5: bus activity with write high
    step(1, 1, 1, 0, 0, 8'hFF, "R5");
    step(1, 1, 1, 1, 1, 8'hFF, "R5");
    // R6: one load pulse moves both
    step(1, 1, 0, 0, 0, 8'h00, "R6");
    step(1, 1, 1, 0, 0, 8'h00, "R6");
    check("R6 chA value", codeA, 12'h23C);
    check("R6 chB value", codeB, 12'hEC3);
    // R9: clear released with write high, zeros stay latched
    step(0, 1, 1, 0, 0, 8'h55, "R1");
    step(1, 1, 1, 1, 1, 8'h55, "R9");
    step(1, 1, 0, 0, 0, 8'h55, "R9");
    step(1, 1, 1, 0, 0, 8'h55, "R9");
    check("R9 zero A", codeA, 12'h000);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic c, w, l;
      c = ($urandom_range(0, 59) != 0);
      w = $urandom_range(0, 2) == 0;
      l = $urandom_range(0, 3) != 0;
      step(c, w, l, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 255)), "");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule